// File: doc/BRIEF.md
# Parallel SAR ADC Sequencing Controller

This controller links a synchronous local-bus target port to an external 12-bit successive-approximation converter with a parallel data port. When the bus master drives the active-low address strobe, the controller launches a conversion. It then waits until two things are true: a minimum conversion time has elapsed, and the converter's busy status has dropped. After that it reads the result back and pulses ready to the bus for one clock.

Two choices are latched along with the strobe. The first picks a full 12-bit conversion or the faster 8-bit conversion. The second picks whether the result comes back as one 12-bit word or as two byte reads. In the two-byte case the controller puts the pieces back together in a single holding register. All phase lengths come from a cycle counter, and the cycle counts are derived from the local clock frequency and the converter's conversion and access times.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and afterwards in idle, the converter is disabled (`adc_ce`=0, `adc_cs_n`=1), `bus_ready` is 0 and `bus_data` is 0.
- R2: A low `bus_strobe_n` in idle starts a conversion. The converter is enabled with `adc_rc`=0 for exactly ACC_CYC clocks (8 by default). During that window `adc_a0` equals the latched `cfg_short_conv` (1 = 8-bit conversion, 0 = 12-bit conversion). `adc_rc` never changes while the converter stays enabled.
- R3: The first read enable comes at least CONV_CYC clocks (1250) after the start window ends, or at least SHORT_CYC clocks (500) for an 8-bit conversion. No read is ever enabled while `adc_busy` is 1.
- R4: No read begins until `bus_last` has been seen high after the strobe, during the start or wait phase.
- R5: With `cfg_two_byte`=0, there is a single read window of ACC_CYC clocks with `adc_rc`=1, `adc_a0`=0 and `adc_wide`=1. `bus_data` then equals the 12-bit `adc_data`.
- R6: With `cfg_two_byte`=1, `adc_wide`=0 and there are two read windows of ACC_CYC clocks each. The window with `adc_a0`=0 supplies result bits 11:4 from `adc_data[11:4]`. The window with `adc_a0`=1 supplies result bits 3:0 from `adc_data[11:8]`.
- R7: `bus_ready` is high for exactly one clock, after the final capture, and `bus_data` holds the complete result in that cycle.
- R8: A strobe that arrives while a transfer is under way is ignored. It starts no further conversion and produces no extra ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe_n | input | 1 | Active-low address strobe that starts a transfer |
| bus_last | input | 1 | Last-beat marker that permits the data read |
| cfg_short_conv | input | 1 | 1 selects the 8-bit conversion |
| cfg_two_byte | input | 1 | 1 selects the read as two bytes |
| bus_ready | output | 1 | One-clock ready pulse to the bus master |
| bus_data | output | 12 | Holding register with the assembled result |
| adc_ce | output | 1 | Converter enable, active high |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rc | output | 1 | 0 = start conversion, 1 = read |
| adc_a0 | output | 1 | Conversion length select / byte address |
| adc_wide | output | 1 | 1 = 12-bit parallel read, 0 = byte reads |
| adc_busy | input | 1 | Converter status, high during conversion |
| adc_data | input | 12 | Converter parallel output; bytes appear on bits 11:4 |

## Verification
The transfers cover all four combinations of conversion length and read width, so a wrong byte order, a missing nibble or a short-conversion value that is not padded each show up as a data mismatch. Busy durations below the minimum count and above it separate a controller that trusts only the timer from one that also waits for the status line. A last-beat that arrives late checks that the read is gated on that signal. A strobe repeated while busy checks that such strobes are dropped and not queued. Extreme sample values (all ones, all zeros, only the low nibble set) expose a dropped or shifted field.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_RD_HI = 3'd3,
    ST_RD_LO = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_t;

  // Round a duration up to a whole number of local clock cycles.
  function automatic int ns_to_cycles(input int clk_khz, input int dur_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(dur_ns);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int DW   = 12,
  parameter int BYTE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_word,
  input  logic          cap_hi,
  input  logic          cap_lo,
  input  logic [DW-1:0] adc_data,
  output logic [DW-1:0] result
);

  localparam int NIB = DW - BYTE;

  logic [DW-1:0] res_q;
  logic [DW-1:0] res_d;
  logic          res_en;

  always_comb begin
    res_d  = res_q;
    res_en = cap_word || cap_hi || cap_lo;
    if (cap_word) begin
      res_d = adc_data;
    end else if (cap_hi) begin
      res_d[DW-1:NIB] = adc_data[DW-1:NIB];
    end else if (cap_lo) begin
      // the low field arrives packed into the top of the byte lane
      res_d[NIB-1:0] = adc_data[DW-1:DW-NIB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int TW        = 11,
  parameter int ACC_CYC   = 8,
  parameter int CONV_CYC  = 1250,
  parameter int SHORT_CYC = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe_n,
  input  logic          bus_last,
  input  logic          cfg_short_conv,
  input  logic          cfg_two_byte,
  input  logic          adc_busy,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          cap_word,
  output logic          cap_hi,
  output logic          cap_lo,
  output logic          bus_ready,
  output logic          adc_ce,
  output logic          adc_cs_n,
  output logic          adc_rc,
  output logic          adc_a0,
  output logic          adc_wide
);

  localparam logic [TW-1:0] ACC_LD   = TW'(ACC_CYC - 1);
  localparam logic [TW-1:0] CONV_LD  = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] SHORT_LD = TW'(SHORT_CYC - 1);

  seq_state_t state_q, state_d;
  logic       short_q, two_q, armed_q;
  logic       launch;
  logic       arm_set;

  // next-state and phase timer control
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_word = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!bus_strobe_n) begin
          state_d  = ST_START;
          tmr_load = 1'b1;
          tmr_val  = ACC_LD;
        end
      end
      ST_START: begin
        if (tmr_expired) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = short_q ? SHORT_LD : CONV_LD;
        end
      end
      ST_WAIT: begin
        if (tmr_expired && !adc_busy && armed_q) begin
          state_d  = ST_RD_HI;
          tmr_load = 1'b1;
          tmr_val  = ACC_LD;
        end
      end
      ST_RD_HI: begin
        if (tmr_expired) begin
          if (two_q) begin
            cap_hi   = 1'b1;
            state_d  = ST_RD_LO;
            tmr_load = 1'b1;
            tmr_val  = ACC_LD;
          end else begin
            cap_word = 1'b1;
            state_d  = ST_DONE;
          end
        end
      end
      ST_RD_LO: begin
        if (tmr_expired) begin
          cap_lo  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // transfer options are captured with the strobe
  assign launch  = (state_q == ST_IDLE) && !bus_strobe_n;
  assign arm_set = bus_last && ((state_q == ST_START) || (state_q == ST_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      two_q   <= 1'b0;
    end else if (launch) begin
      short_q <= cfg_short_conv;
      two_q   <= cfg_two_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (launch) begin
      armed_q <= 1'b0;
    end else if (arm_set) begin
      armed_q <= 1'b1;
    end
  end

  // converter control lines decoded from the state register
  always_comb begin
    adc_ce    = (state_q == ST_START) || (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
    adc_cs_n  = !adc_ce;
    adc_rc    = (state_q != ST_START);
    adc_a0    = (state_q == ST_START) ? short_q : (state_q == ST_RD_LO);
    adc_wide  = !two_q;
    bus_ready = (state_q == ST_DONE);
  end

  // R8: a conversion can only be launched from idle
  p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) != ST_START) |-> $past(state_q) == ST_IDLE);

  // R3: wait is left only with busy low and the minimum time used up
  p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_WAIT && $past(state_q) == ST_WAIT) |-> ($past(!adc_busy) && $past(tmr_expired)));

  // R4: a read needs the last-beat marker
  p_read_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_HI && $past(state_q) == ST_WAIT) |-> $past(armed_q));

  // R7: ready is a single-cycle pulse
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R2: the read/convert line does not change within an enabled window
  p_rc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ce && $past(adc_ce)) |-> adc_rc == $past(adc_rc));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_KHZ       = 50000,
  parameter int CONV_NS       = 25000,
  parameter int SHORT_CONV_NS = 10000,
  parameter int ACCESS_NS     = 150,
  parameter int DW            = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe_n,
  input  logic          bus_last,
  input  logic          cfg_short_conv,
  input  logic          cfg_two_byte,
  output logic          bus_ready,
  output logic [DW-1:0] bus_data,
  output logic          adc_ce,
  output logic          adc_cs_n,
  output logic          adc_rc,
  output logic          adc_a0,
  output logic          adc_wide,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data
);

  localparam int ACC_CYC   = ns_to_cycles(CLK_KHZ, ACCESS_NS);
  localparam int CONV_CYC  = ns_to_cycles(CLK_KHZ, CONV_NS);
  localparam int SHORT_CYC = ns_to_cycles(CLK_KHZ, SHORT_CONV_NS);
  localparam int MAX_CYC   = (CONV_CYC > ACC_CYC) ? CONV_CYC : ACC_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          cap_word, cap_hi, cap_lo;

  adc_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  adc_seq_fsm #(
    .TW        (TW),
    .ACC_CYC   (ACC_CYC),
    .CONV_CYC  (CONV_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_strobe_n   (bus_strobe_n),
    .bus_last       (bus_last),
    .cfg_short_conv (cfg_short_conv),
    .cfg_two_byte   (cfg_two_byte),
    .adc_busy       (adc_busy),
    .tmr_expired    (tmr_expired),
    .tmr_load       (tmr_load),
    .tmr_val        (tmr_val),
    .cap_word       (cap_word),
    .cap_hi         (cap_hi),
    .cap_lo         (cap_lo),
    .bus_ready      (bus_ready),
    .adc_ce         (adc_ce),
    .adc_cs_n       (adc_cs_n),
    .adc_rc         (adc_rc),
    .adc_a0         (adc_a0),
    .adc_wide       (adc_wide)
  );

  adc_seq_result #(.DW(DW), .BYTE(8)) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_word (cap_word),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .adc_data (adc_data),
    .result   (bus_data)
  );

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int ACC   = 8;     // 150 ns at 50 MHz, rounded up
  localparam int CONV  = 1250;  // 25 us at 50 MHz
  localparam int SHORT = 500;   // 10 us at 50 MHz

  logic        clk, rst_n;
  logic        bus_strobe_n, bus_last, cfg_short_conv, cfg_two_byte;
  logic        bus_ready;
  logic [11:0] bus_data;
  logic        adc_ce, adc_cs_n, adc_rc, adc_a0, adc_wide, adc_busy;
  logic [11:0] adc_data;

  int n_chk, n_fail;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_strobe_n(bus_strobe_n), .bus_last(bus_last),
    .cfg_short_conv(cfg_short_conv), .cfg_two_byte(cfg_two_byte),
    .bus_ready(bus_ready), .bus_data(bus_data), .adc_ce(adc_ce), .adc_cs_n(adc_cs_n),
    .adc_rc(adc_rc), .adc_a0(adc_a0), .adc_wide(adc_wide), .adc_busy(adc_busy),
    .adc_data(adc_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural converter
  logic [11:0] m_sample, m_word;
  int          m_busy_len, m_bcnt;
  logic        m_en;
  assign m_en = adc_ce && !adc_cs_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_busy <= 1'b0; m_bcnt <= 0; m_word <= 12'h0;
    end else if (m_en && !adc_rc) begin
      adc_busy <= 1'b1; m_bcnt <= m_busy_len;
      m_word   <= adc_a0 ? {m_sample[11:4], 4'h0} : m_sample;
    end else if (m_bcnt != 0) begin
      m_bcnt <= m_bcnt - 1;
    end else begin
      adc_busy <= 1'b0;
    end
  end

  assign adc_data = !(m_en && adc_rc) ? 12'h000 :
                    adc_wide ? m_word :
                    adc_a0   ? {m_word[3:0], 8'h00} : {m_word[11:4], 4'h0};

  // phase monitor
  int mon_start, mon_starts, mon_gap, mon_hi, mon_lo, mon_busyrd, mon_widebad;
  logic mon_a0s, mon_prev_conv, mon_exp_wide;

  always @(negedge clk) begin
    if (m_en && !adc_rc) begin
      mon_start++;
      mon_a0s = adc_a0;
      if (!mon_prev_conv) mon_starts++;
    end
    if (!m_en && mon_starts > 0 && mon_hi == 0) mon_gap++;
    if (m_en && adc_rc) begin
      if (adc_busy) mon_busyrd++;
      if (adc_a0) mon_lo++; else mon_hi++;
      if (adc_wide != mon_exp_wide) mon_widebad++;
    end
    mon_prev_conv = m_en && !adc_rc;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_result(input logic [11:0] s, input bit short_c);
    return short_c ? {s[11:4], 4'h0} : s;
  endfunction

  task automatic xfer(input bit two, input bit short_c, input logic [11:0] smp,
                      input int busy_len, input int last_dly, input bit extra);
    bit got;
    int rdy_at;
    logic [11:0] dat;
    got = 1'b0; rdy_at = 0; dat = 12'h0;
    m_sample = smp; m_busy_len = busy_len;
    mon_start = 0; mon_starts = 0; mon_gap = 0; mon_hi = 0; mon_lo = 0;
    mon_busyrd = 0; mon_widebad = 0; mon_exp_wide = !two;
    @(negedge clk);
    cfg_two_byte = two; cfg_short_conv = short_c; bus_strobe_n = 1'b0;
    @(negedge clk);
    bus_strobe_n = 1'b1;
    for (int c = 0; c < 6000 && !got; c++) begin
      @(negedge clk);
      bus_last     = (c == last_dly);
      bus_strobe_n = !(extra && (c == 40 || c == 41));
      if (bus_ready) begin got = 1'b1; rdy_at = c; dat = bus_data; end
    end
    bus_last = 1'b0; bus_strobe_n = 1'b1;
    chk(got, "R7", "ready seen", int'(got), 1);
    chk(dat == exp_result(smp, short_c), two ? "R6" : "R5", "result", int'(dat),
        int'(exp_result(smp, short_c)));
    chk(mon_start == ACC, "R2", "convert window", mon_start, ACC);
    chk(mon_a0s == short_c, "R2", "length select", int'(mon_a0s), int'(short_c));
    chk(mon_gap >= (short_c ? SHORT : CONV), "R3", "conversion gap", mon_gap,
        short_c ? SHORT : CONV);
    chk(mon_busyrd == 0, "R3", "read during busy", mon_busyrd, 0);
    chk(rdy_at > last_dly, "R4", "ready after last beat", rdy_at, last_dly + 1);
    chk(mon_hi == ACC && mon_lo == (two ? ACC : 0), two ? "R6" : "R5", "read windows",
        mon_hi * 100 + mon_lo, ACC * 100 + (two ? ACC : 0));
    chk(mon_widebad == 0, two ? "R6" : "R5", "width line", mon_widebad, 0);
    @(negedge clk);
    chk(!bus_ready, "R7", "ready one clock", int'(bus_ready), 0);
    repeat (4) @(negedge clk);
    chk(mon_starts == 1 && !adc_ce, "R8", "single conversion", mon_starts, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_strobe_n = 1'b1; bus_last = 1'b0;
    cfg_short_conv = 1'b0; cfg_two_byte = 1'b0;
    m_sample = 12'h0; m_busy_len = 10;
    mon_prev_conv = 1'b0; mon_exp_wide = 1'b1;
    repeat (3) @(negedge clk);
    chk(!adc_ce && adc_cs_n && !bus_ready && bus_data == 0, "R1", "in reset",
        int'({adc_ce, adc_cs_n, bus_ready}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!adc_ce && adc_cs_n && !bus_ready && bus_data == 0, "R1", "idle after reset",
        int'({adc_ce, adc_cs_n, bus_ready}), 2);
    // directed corners
    xfer(1'b0, 1'b0, 12'hA5C, 200,  5,    1'b0);
    xfer(1'b1, 1'b0, 12'h3E7, 200,  5,    1'b0);
    xfer(1'b0, 1'b1, 12'hFFF, 100,  5,    1'b0);
    xfer(1'b1, 1'b1, 12'h9B6, 100,  5,    1'b0);
    xfer(1'b1, 1'b0, 12'h00F, 1800, 5,    1'b0);
    xfer(1'b0, 1'b0, 12'h000, 300,  1600, 1'b0);
    xfer(1'b1, 1'b0, 12'h801, 600,  20,   1'b1);
    // random mix
    for (int i = 0; i < 14; i++) begin
      xfer(1'($urandom), 1'($urandom), 12'($urandom),
           50 + int'($urandom % 1700), int'($urandom % 1400), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule